// File: doc/BRIEF.md
# Indirect Device Register Access Bridge

This block lets a host processor read and write registers of devices on a backplane bus. On that bus the bridge is the bus-owning CPU. The host never drives bus cycles itself. It loads a target address, and write data for a write, into staging registers in the bridge. It then issues a start command and waits until the bridge reports completion, either by polling a busy flag or by taking a one-cycle done pulse. The status and read data are then available to the host.

Device accesses are only legal while a host-controlled switch holds off DMA bus grants. While the switch is on, devices that request the bus are granted mastership one at a time in fixed priority order, and a grant lasts as long as the device keeps its request up. The sequencer first waits for any master that still holds a grant to let go of the bus. It then runs a bus cycle as a master/slave sync handshake. A programmable cycle limit ends the cycle if the slave never answers.

Top module: `busreg_bridge`

## Requirements
- R1: After reset the DMA grant enable bit (CTRL bit 0) reads 1, STATUS reads 0, no DMA grant is active and master sync is low.
- R2: While the enable bit is 0, no new DMA grant is issued, whatever requests are pending.
- R3: An accepted access drives the address and the write control (bus_wr high for a write) before master sync rises. Master sync then stays high until slave sync is seen. After that it drops, and completion waits for slave sync to drop.
- R4: A start command (CTRL bit 1) written with the enable bit (CTRL bit 0) at 1 is rejected. STATUS bit 1 is set and no bus cycle runs.
- R5: A read cycle latches the bus input data into RDATA (select 5). A write cycle drives the WDATA register (select 2) on the bus data output and stores it at the target.
- R6: If slave sync is not seen within TLIM (select 3) cycles of master sync, master sync is held for exactly TLIM cycles. The access then ends with STATUS bit 2 set and RDATA forced to zero. A later good access clears bit 2.
- R7: STATUS bit 0 (busy) is set from an accepted start until the handshakes finish. Writes to ADDR (select 1), WDATA and TLIM while busy are ignored.
- R8: When the enable bit is 1 and no grant is held, the lowest-numbered requesting device is granted. The grant is held until that device drops its request, and at most one grant is active.
- R9: A bus cycle does not begin while a DMA grant is still held. Master sync stays low until the granted device releases the bus.
- R10: Each completed bus cycle, including a timed-out one, gives exactly one one-cycle pulse on hst_done together with STATUS bit 3 (done). A rejected start gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_sel | input | 3 | Register select: 0 CTRL, 1 ADDR, 2 WDATA, 3 TLIM, 4 STATUS, 5 RDATA |
| hst_wdata | input | W | Host write data |
| hst_rdata | output | W | Selected register contents |
| hst_done | output | 1 | One-cycle completion pulse |
| dma_req | input | NDEV | DMA bus requests from devices |
| dma_gnt | output | NDEV | DMA bus grants, at most one set |
| bus_addr | output | W | Target address during a cycle |
| bus_wr | output | 1 | High for a write cycle |
| bus_dout | output | W | Write data during a write cycle |
| bus_din | input | W | Read data from the slave |
| bus_msyn | output | 1 | Master sync |
| bus_ssyn | input | 1 | Slave sync |

## Verification
A sequencer stuck outside its idle state shows at the ports as STATUS busy that never clears and no hst_done pulse. It is seen on the first poll after the expected number of handshake cycles. A broken grant gate shows within one or two cycles as a grant while the enable bit is clear, or as a grant that overlaps master sync. Wrong latching shows on the next RDATA read as stale or non-zero data after a timeout. Because the host registers are read back through the normal select path, an ignored write that was not in fact ignored appears on the first read after busy drops.

// File: rtl/busreg_pkg.sv
package busreg_pkg;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_WDATA = 3'd2;
    localparam logic [SEL_W-1:0] SEL_TLIM  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STAT  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_RDATA = 3'd5;

    localparam int CTRL_EN = 0;
    localparam int CTRL_GO = 1;
    localparam int CTRL_WR = 2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAITBUS,
        SQ_SETUP,
        SQ_MSYN,
        SQ_RELEASE
    } seq_state_t;

    typedef struct packed {
        logic done;
        logic tmo;
        logic rej;
        logic busy;
    } stat_t;

    function automatic logic drives_bus(seq_state_t s);
        return (s == SQ_SETUP) || (s == SQ_MSYN) || (s == SQ_RELEASE);
    endfunction

endpackage

// File: rtl/busreg_hostregs.sv
module busreg_hostregs
    import busreg_pkg::*;
#(
    parameter int W        = 16,
    parameter int TLIM_RST = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hst_wr,
    input  logic [SEL_W-1:0] hst_sel,
    input  logic [W-1:0]     hst_wdata,
    output logic [W-1:0]     hst_rdata,
    output logic             hst_done,
    input  logic             busy,
    input  logic             cyc_end,
    input  logic             cyc_tmo,
    input  logic [W-1:0]     cyc_rdata,
    output logic             dma_en,
    output logic             go,
    output logic             dir_wr,
    output logic [W-1:0]     addr_q,
    output logic [W-1:0]     wdata_q,
    output logic [W-1:0]     tlim_q,
    output logic [W-1:0]     rdata_q,
    output logic             st_tmo
);

    logic  start_req;
    logic  rej_q, done_q, tmo_q;
    stat_t stat;

    assign start_req = hst_wr && (hst_sel == SEL_CTRL) && hst_wdata[CTRL_GO] && !busy;
    assign go        = start_req && !hst_wdata[CTRL_EN];
    assign st_tmo    = tmo_q;
    assign stat      = '{done: done_q, tmo: tmo_q, rej: rej_q, busy: busy};

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_en   <= 1'b1;
            dir_wr   <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            tlim_q   <= TLIM_RST[W-1:0];
            rdata_q  <= '0;
            rej_q    <= 1'b0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
            hst_done <= 1'b0;
        end else begin
            hst_done <= cyc_end;
            if (hst_wr && hst_sel == SEL_CTRL)
                dma_en <= hst_wdata[CTRL_EN];
            if (hst_wr && !busy) begin
                case (hst_sel)
                    SEL_ADDR:  addr_q  <= hst_wdata;
                    SEL_WDATA: wdata_q <= hst_wdata;
                    SEL_TLIM:  tlim_q  <= hst_wdata;
                    default: ;
                endcase
            end
            if (start_req) begin
                rej_q  <= hst_wdata[CTRL_EN];
                done_q <= 1'b0;
                tmo_q  <= 1'b0;
                if (go)
                    dir_wr <= hst_wdata[CTRL_WR];
            end
            if (cyc_end) begin
                done_q <= 1'b1;
                tmo_q  <= cyc_tmo;
                if (cyc_tmo)
                    rdata_q <= '0;
                else if (!dir_wr)
                    rdata_q <= cyc_rdata;
            end
        end
    end

    always_comb begin
        case (hst_sel)
            SEL_CTRL:  hst_rdata = {{(W-3){1'b0}}, dir_wr, 1'b0, dma_en};
            SEL_ADDR:  hst_rdata = addr_q;
            SEL_WDATA: hst_rdata = wdata_q;
            SEL_TLIM:  hst_rdata = tlim_q;
            SEL_STAT:  hst_rdata = {{(W-4){1'b0}}, stat};
            SEL_RDATA: hst_rdata = rdata_q;
            default:   hst_rdata = '0;
        endcase
    end

endmodule

// File: rtl/busreg_dmagate.sv
module busreg_dmagate #(
    parameter int NDEV = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dma_en,
    input  logic            seq_busy,
    input  logic [NDEV-1:0] dma_req,
    output logic [NDEV-1:0] dma_gnt,
    output logic            bus_held
);

    logic [NDEV-1:0] gnt_q;
    logic [NDEV-1:0] keep;
    logic [NDEV-1:0] pick;

    // isolate the lowest-numbered pending request
    assign pick = dma_req & (~dma_req + NDEV'(1));

    for (genvar i = 0; i < NDEV; i++) begin : g_keep
        assign keep[i] = gnt_q[i] & dma_req[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            gnt_q <= '0;
        else if (|gnt_q)
            gnt_q <= keep;
        else if (dma_en && !seq_busy)
            gnt_q <= pick;
    end

    assign dma_gnt  = gnt_q;
    assign bus_held = |gnt_q;

endmodule

// File: rtl/busreg_seq.sv
module busreg_seq
    import busreg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         dir_wr,
    input  logic [W-1:0] addr_q,
    input  logic [W-1:0] wdata_q,
    input  logic [W-1:0] tlim_q,
    input  logic         bus_held,
    output logic         busy,
    output logic         cyc_end,
    output logic         cyc_tmo,
    output logic [W-1:0] cyc_rdata,
    output logic [W-1:0] bus_addr,
    output logic [W-1:0] bus_dout,
    output logic         bus_wr,
    output logic         bus_msyn,
    input  logic [W-1:0] bus_din,
    input  logic         bus_ssyn
);

    seq_state_t   state;
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_nx;
    logic [W-1:0] rd_q;
    logic         cnt_last;
    logic         drive;

    assign cnt_nx   = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign cnt_last = cnt_nx >= {1'b0, tlim_q};
    assign drive    = drives_bus(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt_q <= '0;
            rd_q  <= '0;
        end else begin
            case (state)
                SQ_IDLE:    if (go) state <= SQ_WAITBUS;
                SQ_WAITBUS: if (!bus_held) state <= SQ_SETUP;
                SQ_SETUP: begin
                    cnt_q <= '0;
                    state <= SQ_MSYN;
                end
                SQ_MSYN: begin
                    if (bus_ssyn) begin
                        rd_q  <= bus_din;
                        state <= SQ_RELEASE;
                    end else if (cnt_last) begin
                        state <= SQ_IDLE;
                    end else begin
                        cnt_q <= cnt_nx[W-1:0];
                    end
                end
                SQ_RELEASE: if (!bus_ssyn) state <= SQ_IDLE;
                default:    state <= SQ_IDLE;
            endcase
        end
    end

    assign busy      = (state != SQ_IDLE);
    assign cyc_tmo   = (state == SQ_MSYN) && !bus_ssyn && cnt_last;
    assign cyc_end   = cyc_tmo || ((state == SQ_RELEASE) && !bus_ssyn);
    assign cyc_rdata = rd_q;
    assign bus_msyn  = (state == SQ_MSYN);
    assign bus_addr  = drive ? addr_q : '0;
    assign bus_wr    = drive && dir_wr;
    assign bus_dout  = (drive && dir_wr) ? wdata_q : '0;

endmodule

// File: rtl/busreg_bridge.sv
module busreg_bridge
    import busreg_pkg::*;
#(
    parameter int W        = 16,
    parameter int NDEV     = 4,
    parameter int TLIM_RST = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hst_wr,
    input  logic [SEL_W-1:0] hst_sel,
    input  logic [W-1:0]     hst_wdata,
    output logic [W-1:0]     hst_rdata,
    output logic             hst_done,
    input  logic [NDEV-1:0]  dma_req,
    output logic [NDEV-1:0]  dma_gnt,
    output logic [W-1:0]     bus_addr,
    output logic             bus_wr,
    output logic [W-1:0]     bus_dout,
    input  logic [W-1:0]     bus_din,
    output logic             bus_msyn,
    input  logic             bus_ssyn
);

    logic         seq_busy, cyc_end, cyc_tmo, go, dir_wr, dma_en, bus_held, st_tmo;
    logic [W-1:0] cyc_rdata, addr_q, wdata_q, tlim_q, rdata_q;

    busreg_hostregs #(.W(W), .TLIM_RST(TLIM_RST)) u_regs (
        .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_sel(hst_sel),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_done(hst_done),
        .busy(seq_busy), .cyc_end(cyc_end), .cyc_tmo(cyc_tmo),
        .cyc_rdata(cyc_rdata), .dma_en(dma_en), .go(go), .dir_wr(dir_wr),
        .addr_q(addr_q), .wdata_q(wdata_q), .tlim_q(tlim_q),
        .rdata_q(rdata_q), .st_tmo(st_tmo)
    );

    busreg_dmagate #(.NDEV(NDEV)) u_gate (
        .clk(clk), .rst(rst), .dma_en(dma_en), .seq_busy(seq_busy),
        .dma_req(dma_req), .dma_gnt(dma_gnt), .bus_held(bus_held)
    );

    busreg_seq #(.W(W)) u_seq (
        .clk(clk), .rst(rst), .go(go), .dir_wr(dir_wr), .addr_q(addr_q),
        .wdata_q(wdata_q), .tlim_q(tlim_q), .bus_held(bus_held),
        .busy(seq_busy), .cyc_end(cyc_end), .cyc_tmo(cyc_tmo),
        .cyc_rdata(cyc_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_wr(bus_wr), .bus_msyn(bus_msyn), .bus_din(bus_din),
        .bus_ssyn(bus_ssyn)
    );

endmodule

// File: rtl/busreg_bridge_chk.sv
module busreg_bridge_chk #(
    parameter int W    = 16,
    parameter int NDEV = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [NDEV-1:0] dma_gnt,
    input logic            bus_msyn,
    input logic            bus_ssyn,
    input logic            dma_en,
    input logic            seq_busy,
    input logic [W-1:0]    addr_q,
    input logic [W-1:0]    rdata_q,
    input logic            st_tmo,
    input logic            hst_done
);

    // R8
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_gnt));

    // R2
    gnt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|dma_gnt) |-> $past(dma_en));

    // R9
    msyn_excl_chk: assert property (@(posedge clk) disable iff (rst)
        bus_msyn |-> !(|dma_gnt));

    // R3
    msyn_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_msyn) |-> ($past(bus_ssyn) || st_tmo));

    // R7
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        seq_busy |=> $stable(addr_q));

    // R6
    tmo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_tmo) |-> (rdata_q == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hst_done |=> !hst_done);

endmodule

bind busreg_bridge busreg_bridge_chk #(.W(W), .NDEV(NDEV)) u_chk (
    .clk(clk), .rst(rst), .dma_gnt(dma_gnt), .bus_msyn(bus_msyn),
    .bus_ssyn(bus_ssyn), .dma_en(dma_en), .seq_busy(seq_busy),
    .addr_q(addr_q), .rdata_q(rdata_q), .st_tmo(st_tmo), .hst_done(hst_done)
);

// File: tb/busreg_bridge_bench.sv
module busreg_bridge_bench;

    localparam int W    = 16;
    localparam int NDEV = 4;
    localparam logic [2:0] S_CTRL = 3'd0, S_ADDR = 3'd1, S_WDATA = 3'd2,
                           S_TLIM = 3'd3, S_STAT = 3'd4, S_RDATA = 3'd5;
    localparam logic [3:0] NEVER = 4'd15;

    // {write, target[3:0], data[15:0], slave delay[3:0]}
    localparam int NVEC = 6;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 4'h5, 16'h1234, 4'd0},
        {1'b1, 4'hA, 16'hABCD, 4'd2},
        {1'b0, 4'h5, 16'h0000, 4'd1},
        {1'b0, 4'hA, 16'h0000, 4'd3},
        {1'b1, 4'h5, 16'hFFFF, 4'd0},
        {1'b0, 4'h5, 16'h0000, 4'd2}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            hst_wr = 1'b0;
    logic [2:0]      hst_sel = 3'd0;
    logic [W-1:0]    hst_wdata = '0;
    logic [W-1:0]    hst_rdata;
    logic            hst_done;
    logic [NDEV-1:0] dma_req = '0;
    logic [NDEV-1:0] dma_gnt;
    logic [W-1:0]    bus_addr, bus_dout;
    logic [W-1:0]    bus_din = '0;
    logic            bus_wr, bus_msyn;
    logic            bus_ssyn = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [3:0]   slv_dly = 4'd0;
    int           dcnt = 0;
    logic [W-1:0] smem [16];
    logic [W-1:0] refm [16];

    int           rises = 0;
    int           done_cnt = 0;
    int           hi_cnt = 0;
    logic         prev_msyn = 1'b0;
    logic [W-1:0] last_addr = '0;
    logic         last_wr = 1'b0;

    always #2 clk = ~clk;

    busreg_bridge #(.W(W), .NDEV(NDEV)) u_busreg_bridge (
        .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_sel(hst_sel),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_done(hst_done),
        .dma_req(dma_req), .dma_gnt(dma_gnt), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn)
    );

    // slave device model
    initial forever begin
        @(negedge clk);
        if (!bus_msyn) begin
            bus_ssyn = 1'b0;
            dcnt     = 0;
        end else if (!bus_ssyn) begin
            if (slv_dly != NEVER && dcnt >= int'(slv_dly)) begin
                if (bus_wr) smem[bus_addr[3:0]] = bus_dout;
                bus_din  = smem[bus_addr[3:0]];
                bus_ssyn = 1'b1;
            end else begin
                dcnt++;
            end
        end
    end

    // bus monitor
    initial forever begin
        @(negedge clk);
        if (bus_msyn && !prev_msyn) begin
            rises++;
            hi_cnt    = 1;
            last_addr = bus_addr;
            last_wr   = bus_wr;
        end else if (bus_msyn) begin
            hi_cnt++;
        end
        if (hst_done) done_cnt++;
        prev_msyn = bus_msyn;
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] s, input logic [W-1:0] d);
        @(negedge clk);
        hst_wr    = 1'b1;
        hst_sel   = s;
        hst_wdata = d;
        @(negedge clk);
        hst_wr    = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] s, output logic [W-1:0] d);
        @(negedge clk);
        hst_sel = s;
        #1 d = hst_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [W-1:0] s;
        s = 16'h0001;
        for (int k = 0; k < 300 && s[0]; k++) hrd(S_STAT, s);
        chk(req, {15'd0, s[0]}, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int r0, d0;
        for (int i = 0; i < 16; i++) begin smem[i] = '0; refm[i] = '0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hrd(S_CTRL, v); chk("R1 ctrl", v, 16'h0001);
        hrd(S_STAT, v); chk("R1 status", v, 16'h0000);
        chk("R1 gnt", {12'd0, dma_gnt}, 16'h0000);
        chk("R1 msyn", {15'd0, bus_msyn}, 16'h0000);

        // R4 start with grant enable still set
        hwr(S_CTRL, 16'h0003);
        hrd(S_STAT, v); chk("R4 status", v, 16'h0002);
        repeat (10) @(negedge clk);
        chk("R4 no cycle", 16'(rises), 16'd0);
        chk("R10 no done on reject", 16'(done_cnt), 16'd0);

        // R2 grants held off
        hwr(S_CTRL, 16'h0000);
        dma_req = 4'b0110;
        repeat (6) @(negedge clk);
        chk("R2 no grant", {12'd0, dma_gnt}, 16'h0000);

        // R8 priority and hold
        hwr(S_CTRL, 16'h0001);
        repeat (2) @(negedge clk);
        chk("R8 lowest wins", {12'd0, dma_gnt}, 16'h0002);
        dma_req = 4'b0100;
        repeat (3) @(negedge clk);
        chk("R8 next grant", {12'd0, dma_gnt}, 16'h0004);

        // R9 wait for granted master to release
        hwr(S_CTRL, 16'h0000);
        smem[7] = 16'h5A5A; refm[7] = 16'h5A5A;
        slv_dly = 4'd1;
        hwr(S_ADDR, 16'hC007);
        hwr(S_CTRL, 16'h0002);
        repeat (10) @(negedge clk);
        hrd(S_STAT, v); chk("R9 busy while held", v, 16'h0001);
        chk("R9 no msyn", 16'(rises), 16'd0);
        dma_req = 4'b0000;
        wait_idle("R9 finishes");
        hrd(S_STAT, v); chk("R9 status", v, 16'h0008);
        hrd(S_RDATA, v); chk("R9 rdata", v, 16'h5A5A);
        chk("R9 one cycle", 16'(rises), 16'd1);

        // R3 R5 R10 vector walk
        for (int n = 0; n < NVEC; n++) begin
            logic       w;
            logic [3:0] a;
            logic [W-1:0] d;
            {w, a, d, slv_dly} = VEC[n];
            r0 = rises; d0 = done_cnt;
            hwr(S_ADDR, 16'hC000 | {12'd0, a});
            hwr(S_WDATA, d);
            hwr(S_CTRL, {13'd0, w, 1'b1, 1'b0});
            wait_idle("R7 busy clears");
            if (w) refm[a] = d;
            hrd(S_STAT, v); chk("R10 done status", v, 16'h0008);
            chk("R3 one msyn", 16'(rises - r0), 16'd1);
            chk("R3 address", last_addr, 16'hC000 | {12'd0, a});
            chk("R3 direction", {15'd0, last_wr}, {15'd0, w});
            chk("R10 one pulse", 16'(done_cnt - d0), 16'd1);
            if (w) chk("R5 slave stored", smem[a], refm[a]);
            else begin hrd(S_RDATA, v); chk("R5 read data", v, refm[a]); end
        end

        // R6 timeout, R7 writes ignored while busy
        hwr(S_TLIM, 16'd8);
        slv_dly = NEVER;
        hwr(S_ADDR, 16'hC005);
        hwr(S_CTRL, 16'h0002);
        hwr(S_ADDR, 16'h1111);
        hwr(S_WDATA, 16'h2222);
        hwr(S_TLIM, 16'd3);
        hrd(S_STAT, v); chk("R7 busy", v, 16'h0001);
        wait_idle("R6 ends");
        hrd(S_STAT, v); chk("R6 status", v, 16'h000C);
        hrd(S_RDATA, v); chk("R6 rdata zero", v, 16'h0000);
        chk("R6 msyn width", 16'(hi_cnt), 16'd8);
        hrd(S_ADDR, v); chk("R7 addr kept", v, 16'hC005);
        hrd(S_WDATA, v); chk("R7 wdata kept", v, 16'h0000);
        hrd(S_TLIM, v); chk("R7 tlim kept", v, 16'd8);

        // R6 good access clears timeout
        slv_dly = 4'd0;
        hwr(S_CTRL, 16'h0002);
        wait_idle("R6 recover");
        hrd(S_STAT, v); chk("R6 cleared", v, 16'h0008);
        hrd(S_RDATA, v); chk("R5 after timeout", v, refm[5]);
        chk("R10 total pulses", 16'(done_cnt), 16'd9);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule